// File: doc/BRIEF.md
# Interrupt Lifecycle State Tracker

This block holds the lifecycle of a small array of interrupt sources. For each source it keeps whether the interrupt is waiting (pending), being serviced (active), or both at once. It combines three inputs into that state: the hardware request line, which is read as a rising edge or as a level depending on a per-source mode bit; software strobes that set or clear pending; and the acknowledge and deactivate strobes from the servicing side.

A per-source enable decides only whether a pending, non-active interrupt is offered onward through the forward flag. State keeps evolving while the enable is low. Priority, routing, arbitration and register decoding sit elsewhere. This block only supplies, for each source, a two-bit state and a forward flag to that logic.

Top module: `irq_state_tracker`

## Requirements
- R1: `state_o` holds two bits per source, source i in bits [2i+1:2i], with bit 1 = active and bit 0 = pending. The value is 0 for inactive, 1 for pending, 2 for active and 3 for active-and-pending. After reset, with all lines low, every source reads 0.
- R2: In edge mode (`level_mode_i` bit = 0), a rising edge of the request line sampled at a clock edge makes the source pending from that edge on. It stays pending after the line falls.
- R3: In level mode (`level_mode_i` bit = 1), the hardware share of pending equals the request line in the same cycle, with no register delay.
- R4: An acknowledge on a source that is pending and not active makes it active at the next edge. It reads 3 if pending persists (level line still high, a new rising edge, or a software set in the same cycle), and 2 otherwise.
- R5: A deactivate clears active at the next edge and leaves pending untouched, so 3 becomes 1 and 2 becomes 0.
- R6: A further rising edge while the source is already pending has no effect. A single acknowledge then leaves it active with no pending (2).
- R7: In level mode, a software clear-pending in a cycle where the line is high is ignored. A software-set pending then survives the later fall of the line.
- R8: A software set-pending makes the source pending at the next edge and keeps it pending whatever the line does, until an acknowledge or an accepted clear.
- R9: With enable low, state still changes (for example it becomes pending), and `fwd_o` stays 0.
- R10: `fwd_o` of a source is 1 exactly when it is pending, not active, and enabled.
- R11: When acknowledge and deactivate come in the same cycle, the acknowledge is applied first. An edge-mode source that was pending only then ends inactive.
- R12: An acknowledge on a source that is not pending, or on one already active, is ignored. A deactivate on a non-active source is ignored.
- R13: In edge mode, a software clear-pending removes pending from both the edge latch and the software latch, even while the line is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Hardware request lines |
| level_mode_i | input | N_SRC | 1 = level mode, 0 = edge mode |
| enable_i | input | N_SRC | Forwarding enable per source |
| sw_set_i | input | N_SRC | Software set-pending strobe |
| sw_clr_i | input | N_SRC | Software clear-pending strobe |
| ack_i | input | N_SRC | Acknowledge strobe |
| deact_i | input | N_SRC | Deactivate strobe |
| state_o | output | 2*N_SRC | Encoded lifecycle state per source |
| fwd_o | output | N_SRC | Pending, not active and enabled |

## Verification
The hardest situation to reach is the one where a software-set pending has to outlive a level line. A clear has to arrive while the line is high, and the line must then fall with no acknowledge in between. Only then does the retained software latch show at the ports. Directed sequences walk each source through this case, through an acknowledge that coincides with a fresh edge, and through a combined acknowledge and deactivate. A long stretch of random strobes, with a behavioural reference model compared every cycle, then covers the mixed overlaps.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam int unsigned ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE     = 2'd0,
    ST_PEND     = 2'd1,
    ST_ACT      = 2'd2,
    ST_ACT_PEND = 2'd3
  } irq_state_e;

  function automatic irq_state_e pack_state(input logic act, input logic pend);
    return irq_state_e'({act, pend});
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic rise_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_i;
  end

  assign rise_o = req_i & ~req_q;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic req_i,
  input  logic rise_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_take_i,
  output logic pend_o
);
  logic sw_q, edge_q;
  logic lvl_hold, clr_ok;

  assign lvl_hold = level_i & req_i;
  // level mode: clear is refused while the line is high
  assign clr_ok   = clr_i & ~lvl_hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q   <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      sw_q   <= set_i | (sw_q & ~ack_take_i & ~clr_ok);
      edge_q <= ~level_i & (rise_i | (edge_q & ~ack_take_i & ~clr_i));
    end
  end

  assign pend_o = sw_q | edge_q | lvl_hold;

  AST_SET_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o) else $error("set-pending lost");  // R8

  AST_LVL_CLR_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_q && clr_i && lvl_hold && !ack_take_i) |=> sw_q) else $error("level clear taken");  // R7

  AST_EDGE_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && rise_i && !ack_take_i) |=> pend_o) else $error("edge lost");  // R2
endmodule

// File: rtl/irq_active_ctrl.sv
module irq_active_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_take_i,
  input  logic deact_i,
  output logic act_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_o <= 1'b0;
    else         act_o <= (act_o | ack_take_i) & ~deact_i;  // ack before deact
  end

  AST_DEACT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_i |=> !act_o) else $error("deactivate ignored");  // R5

  AST_ACK_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_take_i && !deact_i) |=> act_o) else $error("ack not taken");  // R4

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_take_i && !deact_i) |=> (act_o == $past(act_o))) else $error("spurious change");  // R12
endmodule

// File: rtl/irq_src_slice.sv
module irq_src_slice
  import irq_trk_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            level_i,
  input  logic            enable_i,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic            ack_i,
  input  logic            deact_i,
  output logic [ST_W-1:0] state_o,
  output logic            fwd_o
);
  logic rise, pend, act, ack_take;

  irq_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .rise_o(rise)
  );

  // acknowledge only counts on a pending, non-active source
  assign ack_take = ack_i & pend & ~act;

  irq_pend_ctrl u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level_i),
    .req_i     (req_i),
    .rise_i    (rise),
    .set_i     (set_i),
    .clr_i     (clr_i),
    .ack_take_i(ack_take),
    .pend_o    (pend)
  );

  irq_active_ctrl u_act (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_take_i(ack_take),
    .deact_i   (deact_i),
    .act_o     (act)
  );

  assign state_o = pack_state(act, pend);
  assign fwd_o   = pend & ~act & enable_i;

  AST_FWD_NOT_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[1] |-> !fwd_o) else $error("active source forwarded");  // R10
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
  import irq_trk_pkg::*;
#(
  parameter int unsigned N_SRC = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC-1:0]        level_mode_i,
  input  logic [N_SRC-1:0]        enable_i,
  input  logic [N_SRC-1:0]        sw_set_i,
  input  logic [N_SRC-1:0]        sw_clr_i,
  input  logic [N_SRC-1:0]        ack_i,
  input  logic [N_SRC-1:0]        deact_i,
  output logic [ST_W*N_SRC-1:0]   state_o,
  output logic [N_SRC-1:0]        fwd_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    irq_src_slice u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i[g]),
      .level_i (level_mode_i[g]),
      .enable_i(enable_i[g]),
      .set_i   (sw_set_i[g]),
      .clr_i   (sw_clr_i[g]),
      .ack_i   (ack_i[g]),
      .deact_i (deact_i[g]),
      .state_o (state_o[ST_W*g +: ST_W]),
      .fwd_o   (fwd_o[g])
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i[g] |-> !fwd_o[g]) else $error("disabled source forwarded");  // R9
  end
endmodule

// File: tb/irq_state_tracker_tb.sv
module irq_state_tracker_tb;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, lvl = '0, en = '0, sset = '0, sclr = '0, ack = '0, deact = '0;
  logic [2*N-1:0] state;
  logic [N-1:0] fwd;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  irq_state_tracker #(.N_SRC(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .level_mode_i(lvl), .enable_i(en),
    .sw_set_i(sset), .sw_clr_i(sclr), .ack_i(ack), .deact_i(deact),
    .state_o(state), .fwd_o(fwd)
  );

  // behavioural reference model
  bit m_sw[N], m_edge[N], m_act[N], m_prev[N];

  function automatic bit m_pend(int i);
    return m_sw[i] || m_edge[i] || (lvl[i] && req[i]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_sw[i] = 0; m_edge[i] = 0; m_act[i] = 0; m_prev[i] = 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        bit p, take, rise;
        p = m_pend(i);
        take = ack[i] && p && !m_act[i];
        rise = req[i] && !m_prev[i];
        if (sset[i]) m_sw[i] = 1;
        else if (take) m_sw[i] = 0;
        else if (sclr[i] && !(lvl[i] && req[i])) m_sw[i] = 0;
        if (lvl[i]) m_edge[i] = 0;
        else if (rise) m_edge[i] = 1;
        else if (take || sclr[i]) m_edge[i] = 0;
        if (take) m_act[i] = 1;
        if (deact[i]) m_act[i] = 0;
        m_prev[i] = req[i];
      end
    end
  end

  task automatic chk(string tag, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // model comparison every cycle, mid-period
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        chk("R1 model state", int'(state[2*i +: 2]), int'({m_act[i], m_pend(i)}));
        chk("R10 model fwd", int'(fwd[i]), int'(m_pend(i) && !m_act[i] && en[i]));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    sset = '0; sclr = '0; ack = '0; deact = '0;
  endtask

  function automatic int st(int i);
    return int'(state[2*i +: 2]);
  endfunction

  task automatic look();
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    look();
    for (int i = 0; i < N; i++) chk("R1 reset state", st(i), 0);
    chk("R10 reset fwd", int'(fwd), 0);

    lvl = 4'b0110;
    en  = 4'b0111;

    // edge mode, src0
    req[0] = 1; tick(); look();
    chk("R2 edge pends", st(0), 1);
    chk("R10 fwd pending", int'(fwd[0]), 1);
    req[0] = 0; tick(); look();
    chk("R2 stays after fall", st(0), 1);
    req[0] = 1; tick(); req[0] = 0; tick(); look();
    chk("R6 second edge no effect", st(0), 1);
    ack[0] = 1; tick(); look();
    chk("R6 one ack clears all", st(0), 2);
    chk("R10 active not fwd", int'(fwd[0]), 0);
    deact[0] = 1; tick(); look();
    chk("R5 active to idle", st(0), 0);

    // level mode, src1
    req[1] = 1; look();
    chk("R3 level same cycle", st(1), 1);
    tick(); ack[1] = 1; tick(); look();
    chk("R4 ack with level high", st(1), 3);
    deact[1] = 1; tick(); look();
    chk("R5 act-pend to pend", st(1), 1);
    req[1] = 0; look();
    chk("R3 level fall same cycle", st(1), 0);

    // level mode software controls, src2
    sset[2] = 1; tick(); look();
    chk("R8 set with line low", st(2), 1);
    req[2] = 1; sclr[2] = 1; tick(); look();
    chk("R7 clear while high", st(2), 1);
    req[2] = 0; tick(); look();
    chk("R7 set survives fall", st(2), 1);
    chk("R8 still pending", st(2), 1);
    sclr[2] = 1; tick(); look();
    chk("R8 clear with line low", st(2), 0);

    // disabled edge source, src3
    req[3] = 1; tick(); look();
    chk("R9 pends while disabled", st(3), 1);
    chk("R9 no fwd while disabled", int'(fwd[3]), 0);
    en[3] = 1; look();
    chk("R10 fwd after enable", int'(fwd[3]), 1);
    ack[3] = 1; deact[3] = 1; tick(); look();
    chk("R11 ack then deact", st(3), 0);
    ack[3] = 1; tick(); look();
    chk("R12 ack on idle ignored", st(3), 0);
    deact[3] = 1; tick(); look();
    chk("R12 deact on idle ignored", st(3), 0);
    req[3] = 0; tick();

    // edge clear and regenerated ack, src0
    sset[0] = 1; tick(); sclr[0] = 1; tick(); look();
    chk("R13 clear sw latch", st(0), 0);
    req[0] = 1; tick(); sclr[0] = 1; tick(); look();
    chk("R13 clear with line high", st(0), 0);
    req[0] = 0; tick(); req[0] = 1; tick(); req[0] = 0; tick();
    req[0] = 1; ack[0] = 1; tick(); look();
    chk("R4 ack with new edge", st(0), 3);
    ack[0] = 1; tick(); look();
    chk("R12 ack on active ignored", st(0), 3);
    deact[0] = 1; tick(); ack[0] = 1; tick(); look();
    chk("R4 ack no regen", st(0), 2);
    deact[0] = 1; req[0] = 0; tick(); look();
    chk("R5 final idle", st(0), 0);

    // random overlap phase, model compared each cycle
    for (int k = 0; k < 3000; k++) begin
      req   = N'($urandom);
      en    = N'($urandom);
      sset  = N'($urandom) & N'($urandom) & N'($urandom);
      sclr  = N'($urandom) & N'($urandom);
      ack   = N'($urandom) & N'($urandom);
      deact = N'($urandom) & N'($urandom) & N'($urandom);
      @(posedge clk);
      #1;
    end
    tick(); look();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule